// File: doc/BRIEF.md
# Key-Dependent Reversible Word Scrambler

This block scrambles a data word in a single pass so that a word written to an internal bus or memory can be recovered only with the same key. The network is built from layers of small four-bit cells. In each cell two bits pass straight through and act as selectors. Their value picks a three-bit group out of the cell's twelve key bits. That group drives a reversible transform on the other two bits: one XOR into each bit, then a conditional swap. Fixed bit permutations join the layers. Each permutation sends every cell's selector bits to the transformed positions of the next layer, and every cell draws its four inputs from four different cells of the layer before.

A mode input chooses between scrambling and descrambling on each cycle. The descrambler runs the layers in reverse order and uses the inverse permutations. In each cell it undoes the swap before the XORs, and the unchanged selector bits choose the same key group again. The key is held in a dedicated register that is loaded by a strobe, so a fresh key can be installed for each run of the protected function. The whole network is combinational and its result is captured in one output register.

Top module: `keyed_scrambler`

## Requirements
- R1: While `rst` is high at a rising edge, `data_out` becomes all zeros and the stored key becomes all zeros.
- R2: The stored key takes the value of `key_in` at a rising edge where `key_load` is high, and holds it otherwise. A word presented at that same edge is processed with the previous key. `key_in` has no effect while `key_load` is low.
- R3: A cell maps its 4-bit input so that bits [3:2] are copied unchanged. In forward direction, with A = bit 0, B = bit 1 and a selected group (k0,k1,k2), it computes A^k0 and B^k1 and then swaps the two results when k2 = 1.
- R4: The selector value g = bits [3:2] picks key bits [3g+2:3g] of the cell's 12-bit slice, giving k0 = bit 3g, k1 = 3g+1 and k2 = 3g+2. Cell c (bits [4c+3:4c]) of layer l uses stored-key bits [(l*4+c)*12+11 : (l*4+c)*12].
- R5: Between layers, input bit d of the next layer is taken from output bit src(d) of the previous layer. With i = d/4, p = d%4 and n = 4 cells, src(d) is 4i+2 for p=0, 4((i+1)%n)+3 for p=1, 4((i+2)%n) for p=2, and 4((i+3)%n)+1 for p=3.
- R6: With `mode` = 0 (scramble), `data_out` one clock after the edge shows layer 0, permutation, layer 1, permutation, layer 2, permutation, layer 3 applied to `data_in`.
- R7: With `mode` = 1 (descramble), `data_out` one clock later is the exact inverse of R6 under the same key, so descrambling the scrambled form of x returns x.
- R8: With an all-zero stored key, scrambling reduces to the three chained permutations of R5.
- R9: `mode` is taken anew at every edge. Words in alternating directions on back-to-back cycles are each processed correctly, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Strobe that stores `key_in` in the key register |
| key_in | input | 192 | New key value |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| data_in | input | 16 | Word to transform |
| data_out | output | 16 | Registered result, one cycle after `data_in` |

## Verification
The bench sweeps all 65,536 input words under one key and compares each result with a model computed from the cell and wiring rules. A wrong selector-to-group mapping, a reversed XOR/swap order or a miswired permutation would therefore corrupt some word. Scramble/descramble pairs run on back-to-back cycles under several keys, including an all-ones key. This catches an inverse that undoes the steps in the wrong order, or a mode that is held over from the previous cycle. The bench also checks that a key written on the same edge as a word does not apply to that word. While the strobe is low, `key_in` keeps changing, so a register that captures it without the strobe would give wrong results. An all-zero key must expose the bare permutation.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int CELL_W    = 4;
    localparam int GRP_W     = 3;
    localparam int NGRP      = 4;
    localparam int CELL_KEY  = GRP_W * NGRP;

    typedef enum logic {
        MODE_SCR   = 1'b0,
        MODE_DESCR = 1'b1
    } mode_e;

    // Cell word: selector pair on top, transformed pair below.
    typedef struct packed {
        logic [1:0] sel;
        logic       b;
        logic       a;
    } cell_bits_t;

    // Key group: XOR into a, XOR into b, swap enable.
    typedef struct packed {
        logic swap;
        logic kb;
        logic ka;
    } key_grp_t;

    // Source bit of the previous layer feeding bit d of the next one.
    function automatic int perm_src(input int d, input int ncell);
        int i;
        int p;
        i = d / CELL_W;
        p = d % CELL_W;
        case (p)
            0:       return CELL_W * i + 2;
            1:       return CELL_W * ((i + 1) % ncell) + 3;
            2:       return CELL_W * ((i + 2) % ncell);
            default: return CELL_W * ((i + 3) % ncell) + 1;
        endcase
    endfunction

    function automatic key_grp_t pick_grp(input logic [1:0] sel,
                                          input logic [CELL_KEY-1:0] k);
        return key_grp_t'(k[GRP_W*int'(sel) +: GRP_W]);
    endfunction

    // Behavioural references used by assertions.
    function automatic cell_bits_t cell_fwd_ref(input cell_bits_t x,
                                                input logic [CELL_KEY-1:0] k);
        key_grp_t   g;
        cell_bits_t y;
        logic       ta;
        logic       tb;
        g     = pick_grp(x.sel, k);
        ta    = x.a ^ g.ka;
        tb    = x.b ^ g.kb;
        y.sel = x.sel;
        y.a   = g.swap ? tb : ta;
        y.b   = g.swap ? ta : tb;
        return y;
    endfunction

    function automatic cell_bits_t cell_inv_ref(input cell_bits_t x,
                                                input logic [CELL_KEY-1:0] k);
        key_grp_t   g;
        cell_bits_t y;
        logic       ta;
        logic       tb;
        g     = pick_grp(x.sel, k);
        ta    = g.swap ? x.b : x.a;
        tb    = g.swap ? x.a : x.b;
        y.sel = x.sel;
        y.a   = ta ^ g.ka;
        y.b   = tb ^ g.kb;
        return y;
    endfunction

endpackage

// File: rtl/scr_cell.sv
module scr_cell
    import scr_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [CELL_W-1:0]   cell_in,
    input  logic [CELL_KEY-1:0] cell_key,
    output logic [CELL_W-1:0]   cell_out
);

    cell_bits_t xi;
    cell_bits_t yo;
    key_grp_t   grp;
    logic [GRP_W-1:0] grp_lo;
    logic [GRP_W-1:0] grp_hi;

    assign xi = cell_bits_t'(cell_in);

    // Two-level multiplexer tree: selector bit 0 first, then bit 1.
    always_comb begin
        grp_lo = xi.sel[0] ? cell_key[GRP_W*1 +: GRP_W] : cell_key[GRP_W*0 +: GRP_W];
        grp_hi = xi.sel[0] ? cell_key[GRP_W*3 +: GRP_W] : cell_key[GRP_W*2 +: GRP_W];
        grp    = key_grp_t'(xi.sel[1] ? grp_hi : grp_lo);
    end

    generate
        if (!INVERSE) begin : g_fwd
            logic xa;
            logic xb;
            always_comb begin
                xa     = xi.a ^ grp.ka;
                xb     = xi.b ^ grp.kb;
                yo.sel = xi.sel;
                yo.a   = grp.swap ? xb : xa;
                yo.b   = grp.swap ? xa : xb;
            end
            // R7: the inverse rule recovers the cell input
            always_comb begin
                if (!$isunknown({cell_in, cell_key})) begin
                    p_cell_undo_r7: assert (cell_inv_ref(yo, cell_key) == xi)
                        else $error("forward cell not invertible");
                end
            end
        end else begin : g_inv
            logic sa;
            logic sb;
            always_comb begin
                sa     = grp.swap ? xi.b : xi.a;
                sb     = grp.swap ? xi.a : xi.b;
                yo.sel = xi.sel;
                yo.a   = sa ^ grp.ka;
                yo.b   = sb ^ grp.kb;
            end
            // R7: the forward rule recovers the cell input
            always_comb begin
                if (!$isunknown({cell_in, cell_key})) begin
                    p_cell_redo_r7: assert (cell_fwd_ref(yo, cell_key) == xi)
                        else $error("inverse cell not invertible");
                end
            end
        end
    endgenerate

    assign cell_out = yo;

endmodule

// File: rtl/scr_layer.sv
module scr_layer
    import scr_pkg::*;
#(
    parameter int NCELL   = 4,
    parameter bit INVERSE = 1'b0,
    localparam int W      = NCELL * CELL_W,
    localparam int KW     = NCELL * CELL_KEY
) (
    input  logic [W-1:0]  lay_in,
    input  logic [KW-1:0] lay_key,
    output logic [W-1:0]  lay_out
);

    generate
        for (genvar c = 0; c < NCELL; c++) begin : g_cell
            scr_cell #(.INVERSE(INVERSE)) u_cell (
                .cell_in  (lay_in[c*CELL_W +: CELL_W]),
                .cell_key (lay_key[c*CELL_KEY +: CELL_KEY]),
                .cell_out (lay_out[c*CELL_W +: CELL_W])
            );
        end
    endgenerate

endmodule

// File: rtl/scr_perm.sv
module scr_perm
    import scr_pkg::*;
#(
    parameter int NCELL   = 4,
    parameter bit INVERSE = 1'b0,
    localparam int W      = NCELL * CELL_W
) (
    input  logic [W-1:0] perm_in,
    output logic [W-1:0] perm_out
);

    generate
        for (genvar d = 0; d < W; d++) begin : g_bit
            localparam int SRC = perm_src(d, NCELL);
            if (!INVERSE) begin : g_fwd
                assign perm_out[d] = perm_in[SRC];
            end else begin : g_inv
                assign perm_out[SRC] = perm_in[d];
            end
        end
    endgenerate

    // R5: pure rewiring keeps the number of ones
    always_comb begin
        if (!$isunknown(perm_in)) begin
            p_perm_weight_r5: assert ($countones(perm_out) == $countones(perm_in))
                else $error("permutation changed bit weight");
        end
    end

endmodule

// File: rtl/scr_network.sv
module scr_network
    import scr_pkg::*;
#(
    parameter int NCELL   = 4,
    parameter int NLAYER  = 4,
    parameter bit INVERSE = 1'b0,
    localparam int W      = NCELL * CELL_W,
    localparam int LKW    = NCELL * CELL_KEY,
    localparam int KW     = NLAYER * LKW
) (
    input  logic [W-1:0]  net_in,
    input  logic [KW-1:0] net_key,
    output logic [W-1:0]  net_out
);

    logic [W-1:0] stg_in  [NLAYER];
    logic [W-1:0] stg_out [NLAYER];

    assign stg_in[0] = net_in;

    generate
        for (genvar s = 0; s < NLAYER; s++) begin : g_stage
            // Descrambling walks the layers from last to first.
            localparam int LAY = INVERSE ? (NLAYER - 1 - s) : s;

            scr_layer #(.NCELL(NCELL), .INVERSE(INVERSE)) u_layer (
                .lay_in  (stg_in[s]),
                .lay_key (net_key[LAY*LKW +: LKW]),
                .lay_out (stg_out[s])
            );

            if (s < NLAYER - 1) begin : g_link
                scr_perm #(.NCELL(NCELL), .INVERSE(INVERSE)) u_perm (
                    .perm_in  (stg_out[s]),
                    .perm_out (stg_in[s+1])
                );
            end
        end
    endgenerate

    assign net_out = stg_out[NLAYER-1];

endmodule

// File: rtl/keyed_scrambler.sv
module keyed_scrambler
    import scr_pkg::*;
#(
    parameter int  NCELL  = 4,
    parameter int  NLAYER = 4,
    localparam int DATA_W = NCELL * CELL_W,
    localparam int KEY_W  = NLAYER * NCELL * CELL_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_load,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              mode,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);

    logic [KEY_W-1:0]  key_q;
    logic [DATA_W-1:0] fwd_res;
    logic [DATA_W-1:0] inv_res;
    logic [DATA_W-1:0] sel_res;
    mode_e             mode_s;

    assign mode_s = mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (key_load) begin
            key_q <= key_in;
        end
    end

    scr_network #(.NCELL(NCELL), .NLAYER(NLAYER), .INVERSE(1'b0)) u_fwd (
        .net_in  (data_in),
        .net_key (key_q),
        .net_out (fwd_res)
    );

    scr_network #(.NCELL(NCELL), .NLAYER(NLAYER), .INVERSE(1'b1)) u_inv (
        .net_in  (data_in),
        .net_key (key_q),
        .net_out (inv_res)
    );

    assign sel_res = (mode_s == MODE_DESCR) ? inv_res : fwd_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
        end else begin
            data_out <= sel_res;
        end
    end

    // Chained wiring alone, computed independently of the cell network.
    function automatic logic [DATA_W-1:0] bare_wiring(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] nxt;
        cur = v;
        for (int s = 0; s < NLAYER - 1; s++) begin
            for (int d = 0; d < DATA_W; d++) begin
                nxt[d] = cur[perm_src(d, NCELL)];
            end
            cur = nxt;
        end
        return cur;
    endfunction

    p_key_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !key_load |=> $stable(key_q))
        else $error("key register changed without strobe");

    p_key_take_r2: assert property (@(posedge clk) disable iff (rst)
        key_load |=> (key_q == $past(key_in)))
        else $error("key register missed the strobe");

    p_zero_key_r8: assert property (@(posedge clk) disable iff (rst)
        (key_q == '0 && mode_s == MODE_SCR) |=> (data_out == bare_wiring($past(data_in))))
        else $error("zero key did not reduce to wiring");

endmodule

// File: tb/keyed_scrambler_tb.sv
module keyed_scrambler_tb;

    localparam int DW = 16;
    localparam int KW = 192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_load = 1'b0;
    logic [KW-1:0] key_in = '0;
    logic          mode = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    bit            pend = 1'b0;
    logic [DW-1:0] pend_exp = '0;
    string         pend_tag = "";

    always #2 clk = ~clk;

    keyed_scrambler u_dut (
        .clk      (clk),
        .rst      (rst),
        .key_load (key_load),
        .key_in   (key_in),
        .mode     (mode),
        .data_in  (data_in),
        .data_out (data_out)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [DW-1:0] m_layer(input logic [DW-1:0] v, input logic [KW-1:0] k,
                                              input int l, input bit inv);
        logic [DW-1:0] r;
        r = v;
        for (int c = 0; c < 4; c++) begin
            int   g;
            logic k0, k1, k2, a, b, t;
            g  = int'(v[4*c+2]) + 2 * int'(v[4*c+3]);
            k0 = k[(l*4+c)*12 + 3*g];
            k1 = k[(l*4+c)*12 + 3*g + 1];
            k2 = k[(l*4+c)*12 + 3*g + 2];
            a  = v[4*c];
            b  = v[4*c+1];
            if (!inv) begin
                a = a ^ k0; b = b ^ k1;
                if (k2) begin t = a; a = b; b = t; end
            end else begin
                if (k2) begin t = a; a = b; b = t; end
                a = a ^ k0; b = b ^ k1;
            end
            r[4*c]   = a;
            r[4*c+1] = b;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] m_perm(input logic [DW-1:0] v, input bit inv);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            int s0, s1, s2, s3;
            s0 = 4*i + 2;
            s1 = 4*((i+1)%4) + 3;
            s2 = 4*((i+2)%4);
            s3 = 4*((i+3)%4) + 1;
            if (!inv) begin
                r[4*i] = v[s0]; r[4*i+1] = v[s1]; r[4*i+2] = v[s2]; r[4*i+3] = v[s3];
            end else begin
                r[s0] = v[4*i]; r[s1] = v[4*i+1]; r[s2] = v[4*i+2]; r[s3] = v[4*i+3];
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] m_net(input logic [DW-1:0] x, input logic [KW-1:0] k,
                                            input bit inv);
        logic [DW-1:0] v;
        v = x;
        for (int s = 0; s < 4; s++) begin
            v = m_layer(v, k, inv ? 3 - s : s, inv);
            if (s < 3) v = m_perm(v, inv);
        end
        return v;
    endfunction

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic rnd32(output logic [31:0] r);
        seed = lcg(seed);
        r = seed;
    endtask

    task automatic rnd_key(output logic [KW-1:0] k);
        for (int j = 0; j < KW / 32; j++) begin
            logic [31:0] w;
            rnd32(w);
            k[32*j +: 32] = w;
        end
    endtask

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one word at a falling edge; its result is checked at the next one.
    task automatic step(input logic [DW-1:0] d, input logic md, input logic kl,
                        input logic [KW-1:0] kv, input logic [DW-1:0] ex,
                        input bit chk, input string tag);
        @(negedge clk);
        if (pend) check(data_out, pend_exp, pend_tag);
        data_in  = d;
        mode     = md;
        key_load = kl;
        key_in   = kv;
        pend     = chk;
        pend_exp = ex;
        pend_tag = tag;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [KW-1:0] ka;
        logic [KW-1:0] kx;
        logic [KW-1:0] junk;
        logic [31:0]   w;

        // R1: output stays clear under reset even with a live input word
        data_in = 16'hA5A5;
        repeat (3) @(negedge clk);
        check(data_out, 16'h0000, "R1 reset output");
        rst = 1'b0;

        // R1 R8: key cleared by reset, so scrambling is wiring only
        for (int i = 0; i < 16; i++) begin
            step(16'h1 << i, 1'b0, 1'b0, '0, m_net(16'h1 << i, '0, 1'b0), 1'b1, "R8 one-hot");
        end
        for (int i = 0; i < 48; i++) begin
            rnd32(w);
            step(w[15:0], 1'b0, 1'b0, '0, m_net(w[15:0], '0, 1'b0), 1'b1, "R1 R8 zero key");
        end

        // R2: key written on the same edge does not yet apply
        rnd_key(ka);
        step(16'h3C96, 1'b0, 1'b1, ka, m_net(16'h3C96, '0, 1'b0), 1'b1, "R2 old key");
        rnd_key(junk);
        step(16'h3C96, 1'b0, 1'b0, junk, m_net(16'h3C96, ka, 1'b0), 1'b1, "R2 new key");

        // R3 R4 R5 R6: every word under one key; key_in churns with no strobe (R2)
        for (int x = 0; x < 65536; x++) begin
            if ((x & 255) == 0) rnd_key(junk);
            step(x[15:0], 1'b0, 1'b0, junk, m_net(x[15:0], ka, 1'b0), 1'b1,
                 "R3 R4 R5 R6 R2 sweep");
        end

        // R7 R9: back-to-back scramble/descramble pairs under several keys
        for (int kk = 0; kk < 3; kk++) begin
            if (kk == 2) kx = '1; else rnd_key(kx);
            step(16'h0, 1'b0, 1'b1, kx, '0, 1'b0, "load");
            for (int i = 0; i < 2048; i++) begin
                logic [DW-1:0] y;
                rnd32(w);
                y = m_net(w[15:0], kx, 1'b0);
                step(w[15:0], 1'b0, 1'b0, junk, y, 1'b1, "R6 R9 scramble");
                step(y, 1'b1, 1'b0, junk, w[15:0], 1'b1, "R7 R9 descramble");
            end
        end

        @(negedge clk);
        if (pend) check(data_out, pend_exp, pend_tag);
        finish_run();
    end

endmodule